// File: doc/BRIEF.md
# Key-Sequence Locking Controller with State Restore

This block gates access to a protected circuit's correct behaviour. It drives a corruption word that is XORed into chosen internal nets of that circuit. The word is all zeros only while the user is authenticated. Authentication works by presenting a fixed multi-cycle sequence of key words on the circuit's ordinary primary inputs. There is no separate key port.

After reset the controller sits in the first step of entry state 0 and waits for that entry's sequence. Once the sequence is complete, it enters the single functional state. From there, an external back-jump request sends it back to a locked entry state chosen by an index. On that request the controller captures the protected circuit's state word. Each entry state has its own key sequence. When the sequence for that entry is completed, the controller presents the captured word together with a one-cycle restore strobe, so the protected logic resumes where it stopped.

Top module: `seq_lock_top`

## Requirements
- R1: After reset the block is locked in entry 0, step 0: `auth_o`=0, `restore_o`=0, and `enc_o` equals the locked value for entry 0 / step 0.
- R2: While locked, the key word for (entry e, step s) is the low IN_W bits of y = x ^ (x >> 15), with x = SEED ^ (e·0x9E3779B9) ^ (s·0x85EBCA6B) mod 2^32. When `pi_i` equals the key word at a clock edge, the step advances by one. When the match is at step SEQ_LEN-1, the block becomes authenticated at that edge.
- R3: While locked, any `pi_i` that differs from the expected key word at a clock edge returns the step to 0 of the same entry, and the block stays locked.
- R4: While authenticated, `enc_o` is all zeros. While locked, `enc_o` has an odd number of ones, so it is never zero.
- R5: While locked in (e, s), `enc_o` = {v, p}. Here v is the low ENC_W-1 bits of (s ^ (s>>1)) ^ (3·e), and p is the bit that makes the ones count odd. Consecutive steps of one entry therefore give different words.
- R6: A `bj_req_i` at a clock edge while authenticated locks the block at step 0 of entry `bj_idx_i`. An index of N_ENTRY or more selects entry 0.
- R7: The `prot_st_i` value sampled at an accepted back-jump is presented on `restore_st_o` when the block next becomes authenticated. Before the first back-jump, this value is 0.
- R8: `restore_o` is high for exactly the first cycle after each transition into the authenticated state, and is low otherwise.
- R9: `auth_o` is high exactly when the block is in the authenticated state.
- R10: `bj_req_i` has no effect while locked: it changes neither the entry, the step, nor the captured state word.
- R11: While authenticated, `pi_i` has no effect: the block stays authenticated with `enc_o` zero until a back-jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pi_i | input | IN_W | Primary input bus that carries the key words |
| bj_req_i | input | 1 | Back-jump request |
| bj_idx_i | input | max(1,clog2(N_ENTRY)) | Entry state selected by a back-jump |
| prot_st_i | input | ST_W | Current state word of the protected circuit |
| enc_o | output | ENC_W | Corruption word for the XOR insertion points |
| auth_o | output | 1 | Authenticated flag |
| restore_o | output | 1 | One-cycle strobe: load `restore_st_o` into the protected state |
| restore_st_o | output | ST_W | Captured state word to restore |

## Verification
The bench builds the block with N_ENTRY=3, which gives a 2-bit index. Index 3 is therefore a legal input value that lies out of range, and it exercises the fallback to entry 0. SEQ_LEN=8 with ENC_W=4 gives a 3-bit gray step field plus a parity bit. This makes every step-to-step change of the corruption word visible. IN_W=8 is narrow enough that the random phase, which biases `pi_i` towards the expected key, completes full sequences many times, interleaved with mid-sequence wrong words and back-jumps.

// File: rtl/lk_pkg.sv
package lk_pkg;

  // raw 32-bit key word for entry e, step s
  function automatic logic [31:0] key_word(logic [31:0] seed, int unsigned e, int unsigned s);
    logic [31:0] x;
    x = seed ^ (32'(e) * 32'h9E37_79B9) ^ (32'(s) * 32'h85EB_CA6B);
    return x ^ (x >> 15);
  endfunction

  // core of the locked corruption word (before parity)
  function automatic logic [31:0] enc_core(int unsigned e, int unsigned s);
    logic [31:0] g;
    g = 32'(s) ^ (32'(s) >> 1);
    return g ^ (32'(e) * 32'd3);
  endfunction

endpackage

// File: rtl/lk_key_match.sv
module lk_key_match #(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned SEQ_LEN = 8,
  parameter int unsigned N_ENTRY = 4,
  parameter logic [31:0] SEED    = 32'h5A3C_96E1,
  localparam int unsigned EW = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int unsigned SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic [EW-1:0]   entry_i,
  input  logic [SW-1:0]   step_i,
  input  logic [IN_W-1:0] pi_i,
  output logic            hit_o,
  output logic            last_o
);

  logic [IN_W-1:0] tab [N_ENTRY][SEQ_LEN];
  logic [IN_W-1:0] exp_w;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    for (genvar s = 0; s < SEQ_LEN; s++) begin : g_stp
      assign tab[e][s] = IN_W'(lk_pkg::key_word(SEED, e, s));
    end
  end

  always_comb begin
    exp_w = '0;
    for (int e = 0; e < N_ENTRY; e++)
      for (int s = 0; s < SEQ_LEN; s++)
        if (entry_i == EW'(e) && step_i == SW'(s)) exp_w = tab[e][s];
  end

  assign hit_o  = (pi_i == exp_w);
  assign last_o = (step_i == SW'(SEQ_LEN - 1));

endmodule

// File: rtl/lk_enc_map.sv
module lk_enc_map #(
  parameter int unsigned ENC_W   = 4,
  parameter int unsigned SEQ_LEN = 8,
  parameter int unsigned N_ENTRY = 4,
  localparam int unsigned EW = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int unsigned SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             auth_i,
  input  logic [EW-1:0]    entry_i,
  input  logic [SW-1:0]    step_i,
  output logic [ENC_W-1:0] enc_o
);

  logic [ENC_W-1:0] tab [N_ENTRY][SEQ_LEN];
  logic [ENC_W-1:0] sel;

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    for (genvar s = 0; s < SEQ_LEN; s++) begin : g_stp
      logic [ENC_W-2:0] v;
      assign v          = (ENC_W-1)'(lk_pkg::enc_core(e, s));
      assign tab[e][s]  = {v, ~^v};  // odd ones count, never zero
    end
  end

  always_comb begin
    sel = '0;
    for (int e = 0; e < N_ENTRY; e++)
      for (int s = 0; s < SEQ_LEN; s++)
        if (entry_i == EW'(e) && step_i == SW'(s)) sel = tab[e][s];
  end

  assign enc_o = auth_i ? '0 : sel;

endmodule

// File: rtl/lk_state_vault.sv
module lk_state_vault #(
  parameter int unsigned ST_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [ST_W-1:0] st_i,
  output logic [ST_W-1:0] st_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_o <= '0;
    else if (cap_i) st_o <= st_i;
  end

endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top #(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned SEQ_LEN = 8,
  parameter int unsigned N_ENTRY = 4,
  parameter int unsigned ENC_W   = 4,
  parameter int unsigned ST_W    = 8,
  parameter logic [31:0] SEED    = 32'h5A3C_96E1,
  localparam int unsigned EW = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int unsigned SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  pi_i,
  input  logic             bj_req_i,
  input  logic [EW-1:0]    bj_idx_i,
  input  logic [ST_W-1:0]  prot_st_i,
  output logic [ENC_W-1:0] enc_o,
  output logic             auth_o,
  output logic             restore_o,
  output logic [ST_W-1:0]  restore_st_o
);

  logic          auth_q, auth_d;
  logic [EW-1:0] entry_q, entry_d;
  logic [SW-1:0] step_q, step_d;
  logic          rst_q, rst_d;
  logic          hit, last, cap;

  lk_key_match #(.IN_W(IN_W), .SEQ_LEN(SEQ_LEN), .N_ENTRY(N_ENTRY), .SEED(SEED)) u_match (
    .entry_i(entry_q), .step_i(step_q), .pi_i(pi_i), .hit_o(hit), .last_o(last)
  );

  lk_enc_map #(.ENC_W(ENC_W), .SEQ_LEN(SEQ_LEN), .N_ENTRY(N_ENTRY)) u_enc (
    .auth_i(auth_q), .entry_i(entry_q), .step_i(step_q), .enc_o(enc_o)
  );

  lk_state_vault #(.ST_W(ST_W)) u_vault (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .st_i(prot_st_i), .st_o(restore_st_o)
  );

  always_comb begin
    auth_d  = auth_q;
    entry_d = entry_q;
    step_d  = step_q;
    rst_d   = 1'b0;
    cap     = 1'b0;
    if (auth_q) begin
      if (bj_req_i) begin
        auth_d  = 1'b0;
        cap     = 1'b1;
        step_d  = '0;
        entry_d = (32'(bj_idx_i) < N_ENTRY) ? bj_idx_i : '0;
      end
    end else if (hit) begin
      if (last) begin
        auth_d = 1'b1;
        rst_d  = 1'b1;
        step_d = '0;
      end else begin
        step_d = step_q + SW'(1);
      end
    end else begin
      step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auth_q  <= 1'b0;
      entry_q <= '0;
      step_q  <= '0;
      rst_q   <= 1'b0;
    end else begin
      auth_q  <= auth_d;
      entry_q <= entry_d;
      step_q  <= step_d;
      rst_q   <= rst_d;
    end
  end

  assign auth_o    = auth_q;
  assign restore_o = rst_q;

  p_enc_zero_auth_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auth_o |-> (enc_o == '0));

  p_enc_odd_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auth_o |-> ($countones(enc_o) % 2 == 1));

  p_restore_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o);

  p_restore_on_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auth_o && hit && last) |=> (restore_o && auth_o));

  p_bj_locks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auth_o && bj_req_i) |=> (!auth_o && step_q == '0));

  p_auth_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auth_o && !bj_req_i) |=> auth_o);

  p_wrong_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auth_o && !hit) |=> (!auth_o && step_q == '0 && $stable(entry_q)));

  p_saved_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auth_o |=> $stable(restore_st_o));

endmodule

// File: tb/seq_lock_top_tb.sv
`timescale 1ns/1ps
module seq_lock_top_tb;

  localparam int unsigned IN_W = 8, SEQ_LEN = 8, N_ENTRY = 3, ENC_W = 4, ST_W = 8;
  localparam int unsigned EW = 2;
  localparam logic [31:0] SEED = 32'h5A3C_96E1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [IN_W-1:0] pi_i = '0;
  logic bj_req_i = 1'b0;
  logic [EW-1:0] bj_idx_i = '0;
  logic [ST_W-1:0] prot_st_i = '0;
  logic [ENC_W-1:0] enc_o;
  logic auth_o, restore_o;
  logic [ST_W-1:0] restore_st_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit m_auth = 0, m_rst = 0;
  int unsigned m_ent = 0, m_step = 0;
  logic [ST_W-1:0] m_saved = '0;

  always #2.5 clk_i = ~clk_i;

  seq_lock_top #(.IN_W(IN_W), .SEQ_LEN(SEQ_LEN), .N_ENTRY(N_ENTRY), .ENC_W(ENC_W),
                 .ST_W(ST_W), .SEED(SEED)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pi_i(pi_i), .bj_req_i(bj_req_i), .bj_idx_i(bj_idx_i),
    .prot_st_i(prot_st_i), .enc_o(enc_o), .auth_o(auth_o), .restore_o(restore_o),
    .restore_st_o(restore_st_o)
  );

  function automatic logic [IN_W-1:0] exp_key(int unsigned e, int unsigned s);
    logic [31:0] x;
    x = SEED ^ (e * 32'h9E37_79B9) ^ (s * 32'h85EB_CA6B);
    x = x ^ (x >> 15);
    return x[IN_W-1:0];
  endfunction

  function automatic logic [ENC_W-1:0] exp_enc(int unsigned e, int unsigned s);
    logic [2:0] v;
    logic [31:0] t;
    t = (s ^ (s >> 1)) ^ (3 * e);
    v = t[2:0];
    return {v, ~^v};
  endfunction

  task automatic chk(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: update reference, clock, compare at negedge
  task automatic cyc(logic [IN_W-1:0] pi, bit req, logic [EW-1:0] idx, logic [ST_W-1:0] st);
    logic [ENC_W-1:0] e_exp;
    pi_i = pi; bj_req_i = req; bj_idx_i = idx; prot_st_i = st;
    m_rst = 0;
    if (m_auth) begin
      if (req) begin
        m_auth = 0; m_step = 0; m_saved = st;
        m_ent = (idx < N_ENTRY) ? idx : 0;
      end
    end else if (pi == exp_key(m_ent, m_step)) begin
      if (m_step == SEQ_LEN - 1) begin m_auth = 1; m_rst = 1; m_step = 0; end
      else m_step++;
    end else m_step = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    e_exp = m_auth ? '0 : exp_enc(m_ent, m_step);
    chk("R5 enc_o", enc_o == e_exp, 32'(enc_o), 32'(e_exp));
    chk("R9 auth_o", auth_o == m_auth, 32'(auth_o), 32'(m_auth));
    chk("R8 restore_o", restore_o == m_rst, 32'(restore_o), 32'(m_rst));
    chk("R7 restore_st_o", restore_st_o == m_saved, 32'(restore_st_o), 32'(m_saved));
  endtask

  task automatic unlock(int unsigned e);
    for (int s = 0; s < SEQ_LEN; s++) cyc(exp_key(e, s), 1'b0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [ENC_W-1:0] e0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 auth", auth_o == 1'b0, 32'(auth_o), 0);
    chk("R1 restore", restore_o == 1'b0, 32'(restore_o), 0);
    chk("R1 enc", enc_o == exp_enc(0, 0), 32'(enc_o), 32'(exp_enc(0, 0)));

    // R5 consecutive steps differ; R3 wrong word mid-sequence
    e0 = enc_o;
    cyc(exp_key(0, 0), 0, '0, '0);
    chk("R5 toggle", enc_o != e0, 32'(enc_o), 32'(e0));
    for (int s = 1; s < SEQ_LEN - 1; s++) cyc(exp_key(0, s), 0, '0, '0);
    cyc(exp_key(0, SEQ_LEN - 1) ^ 8'h01, 0, '0, '0);
    chk("R3 restart", !auth_o && enc_o == exp_enc(0, 0), 32'(enc_o), 32'(exp_enc(0, 0)));

    // R2 full sequence; R7 initial saved value 0
    unlock(0);
    chk("R2 authed", auth_o == 1'b1, 32'(auth_o), 1);
    chk("R7 initial restore", restore_o && restore_st_o == '0, 32'(restore_st_o), 0);

    // R11 inputs ignored while authenticated
    for (int k = 0; k < 6; k++) cyc(IN_W'($urandom), 0, '0, '0);
    chk("R11 stays auth", auth_o && enc_o == '0, 32'(enc_o), 0);
    chk("R4 enc zero", enc_o == '0, 32'(enc_o), 0);

    // R6 back-jump to entry 2
    cyc(8'h00, 1, 2'd2, 8'hA5);
    chk("R6 entry2", !auth_o && enc_o == exp_enc(2, 0), 32'(enc_o), 32'(exp_enc(2, 0)));
    // R10 request while locked ignored (pi chosen to be the correct step-0 word)
    cyc(exp_key(2, 0), 1, 2'd1, 8'h3C);
    chk("R10 entry kept", enc_o == exp_enc(2, 1), 32'(enc_o), 32'(exp_enc(2, 1)));
    for (int s = 1; s < SEQ_LEN; s++) cyc(exp_key(2, s), 0, '0, '0);
    chk("R7 restored", restore_o && restore_st_o == 8'hA5, 32'(restore_st_o), 32'hA5);
    chk("R10 saved kept", restore_st_o != 8'h3C, 32'(restore_st_o), 32'hA5);
    cyc(8'h00, 0, '0, '0);
    chk("R8 one cycle", restore_o == 1'b0, 32'(restore_o), 0);

    // R6 out-of-range index falls back to entry 0
    cyc(8'h00, 1, 2'd3, 8'h5A);
    chk("R6 idx3->entry0", enc_o == exp_enc(0, 0), 32'(enc_o), 32'(exp_enc(0, 0)));
    unlock(0);
    chk("R6 entry0 key", auth_o && restore_st_o == 8'h5A, 32'(restore_st_o), 32'h5A);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [IN_W-1:0] pi;
      bit req;
      pi  = (($urandom % 10) < 8) ? exp_key(m_ent, m_step) : IN_W'($urandom);
      req = (($urandom % 8) == 0);
      cyc(pi, req, EW'($urandom), ST_W'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule